// File: doc/BRIEF.md
# Serial Command Stopwatch Controller

This block sits between a byte-wide serial receiver, a byte-wide serial transmitter and a decimal stopwatch counter. Each received byte is decoded as a one-character command. The commands start the stopwatch, stop it, clear it, or ask for a time report. The other bytes have no effect.

A time report takes a copy of the stopwatch's BCD digits in the cycle the request is decoded. It then sends those digits one byte at a time as printable characters. A decimal point comes before the last (tenths) digit, and a carriage return and line feed close the report. Each byte goes out through a valid/ready handshake, so the transmitter can pace the report at any rate. Run, stop and clear commands that arrive during a report still take effect at once.

Top module: `uart_stopwatch_ctrl`

## Requirements
- R1: A received byte 0x67 ('g') sets sw_run high from the next clock edge.
- R2: A received byte 0x73 ('s') sets sw_run low from the next clock edge.
- R3: A received byte 0x63 ('c') produces a one-cycle sw_clear pulse in the next cycle. In that same cycle sw_run goes low, even if it was running.
- R4: Any byte other than 0x67, 0x73, 0x63 and 0x74 changes nothing: sw_run stays as it was, sw_clear stays low, and no report starts.
- R5: A received byte 0x74 ('t') while no report is in progress raises tx_valid in the next cycle, with the first report byte on tx_data.
- R6: A report is NDIG+3 bytes long. The digits come first, most significant first, each sent as 0x30 plus the digit value. A 0x2E ('.') is sent just before the least significant (tenths) digit. The report ends with 0x0D and then 0x0A.
- R7: Every digit in a report comes from bcd_time as sampled in the cycle the 0x74 byte was received. Later changes to bcd_time do not alter the report.
- R8: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold steady. A byte is taken when both are high. tx_valid falls in the cycle after the final 0x0A is taken.
- R9: During a report, 0x67, 0x73 and 0x63 still act on the stopwatch as in R1 to R3. A 0x74 received during a report is ignored.
- R10: While rst_n is low, sw_run, sw_clear and tx_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 8 | Received command byte |
| rx_valid | input | 1 | One-cycle strobe marking rx_data as a new byte |
| tx_data | output | 8 | Report byte offered to the transmitter |
| tx_valid | output | 1 | tx_data holds a byte waiting to be taken |
| tx_ready | input | 1 | Transmitter accepts tx_data this cycle |
| bcd_time | input | 4*NDIG | Stopwatch time, BCD, least significant digit is tenths |
| sw_run | output | 1 | Stopwatch counts while high |
| sw_clear | output | 1 | One-cycle pulse that zeroes the stopwatch |

## Verification
A wrong byte index or a stale snapshot shows up on tx_data within one accepted byte. A sequence that skips a byte or stalls shows up as a report that is too short or too long, or as tx_valid still high after the line feed. A wrongly decoded command shows up on sw_run or sw_clear one cycle after the byte arrives. The bench changes bcd_time in every cycle of a report, so a missing snapshot corrupts the very next digit. Commands are injected in the middle of reports to show any interference between the command path and the report path.

// File: rtl/uart_stopwatch_ctrl.sv
module uart_stopwatch_ctrl #(
  parameter int NDIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [4*NDIG-1:0] bcd_time,
  output logic              sw_run,
  output logic              sw_clear
);
  localparam int LEN = NDIG + 3;
  localparam int IW  = $clog2(LEN + 1);

  logic              busy;
  logic [IW-1:0]     idx;
  logic [4*NDIG-1:0] snap;

  wire cmd_go    = rx_valid && rx_data == 8'h67;
  wire cmd_halt  = rx_valid && rx_data == 8'h73;
  wire cmd_zero  = rx_valid && rx_data == 8'h63;
  wire cmd_tell  = rx_valid && rx_data == 8'h74;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_run   <= 1'b0;
      sw_clear <= 1'b0;
      busy     <= 1'b0;
      idx      <= '0;
      snap     <= '0;
    end else begin
      sw_clear <= cmd_zero;
      if (cmd_zero || cmd_halt) sw_run <= 1'b0;
      else if (cmd_go)          sw_run <= 1'b1;
      if (!busy) begin
        if (cmd_tell) begin
          busy <= 1'b1;
          idx  <= '0;
          snap <= bcd_time;
        end
      end else if (tx_ready) begin
        if (idx == IW'(LEN - 1)) busy <= 1'b0;
        idx <= idx + 1'b1;
      end
    end
  end

  assign tx_valid = busy;

  always_comb begin
    int k;
    k = int'(idx);
    tx_data = 8'h0A;
    if (k < NDIG - 1)       tx_data = 8'h30 + {4'h0, snap[4*(NDIG-1-k) +: 4]};
    else if (k == NDIG - 1) tx_data = 8'h2E;
    else if (k == NDIG)     tx_data = 8'h30 + {4'h0, snap[3:0]};
    else if (k == NDIG + 1) tx_data = 8'h0D;
  end
endmodule

// File: rtl/uart_stopwatch_ctrl_chk.sv
module uart_stopwatch_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       sw_run,
  input logic       sw_clear
);
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> $stable(tx_data));
  a_r3_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |-> $past(rx_valid && rx_data == 8'h63));
  a_r3_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |-> !sw_run);
  a_r1_run_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_run) |-> $past(rx_valid && rx_data == 8'h67));
  a_r5_report_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(rx_valid && rx_data == 8'h74));
endmodule

bind uart_stopwatch_ctrl uart_stopwatch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .sw_run(sw_run), .sw_clear(sw_clear)
);

// File: tb/uart_stopwatch_ctrl_test.sv
module uart_stopwatch_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NDIG = 4;
  localparam int LEN  = NDIG + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_valid = 1'b0;
  logic [7:0] tx_data;
  logic tx_valid;
  logic tx_ready = 1'b0;
  logic [4*NDIG-1:0] bcd_time = '0;
  logic sw_run, sw_clear;

  int checks = 0;
  int failures = 0;
  bit model_run = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_stopwatch_ctrl #(.NDIG(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .bcd_time(bcd_time), .sw_run(sw_run), .sw_clear(sw_clear)
  );

  function automatic logic [7:0] exp_char(input logic [4*NDIG-1:0] t, input int i);
    if (i < NDIG - 1)  return 8'h30 + {4'h0, t[4*(NDIG-1-i) +: 4]};
    if (i == NDIG - 1) return 8'h2E;
    if (i == NDIG)     return 8'h30 + {4'h0, t[3:0]};
    if (i == NDIG + 1) return 8'h0D;
    return 8'h0A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_report(input logic [4*NDIG-1:0] t, input logic [7:0] inj);
    int n;
    bit hold;
    logic [7:0] hd;
    tx_ready = 1'b0;
    bcd_time = t;
    send_cmd(8'h74);
    check(tx_valid === 1'b1, "R5 tx_valid after request", int'(tx_valid), 1);
    check(tx_data === exp_char(t, 0), "R5 first byte", int'(tx_data), int'(exp_char(t, 0)));
    n = 0;
    hold = 1'b0;
    hd = '0;
    for (int cyc = 0; cyc < 400 && n < LEN; cyc++) begin
      rx_valid = 1'b0;
      if (cyc == 3 && inj != 8'h00) begin
        rx_data = inj;
        rx_valid = 1'b1;
      end
      if (hold) begin
        check(tx_valid === 1'b1 && tx_data === hd, "R8 stall hold", int'(tx_data), int'(hd));
      end
      tx_ready = 1'($urandom_range(0, 1));
      bcd_time = $urandom;
      if (tx_valid && tx_ready) begin
        check(tx_data === exp_char(t, n), "R6 R7 report byte", int'(tx_data), int'(exp_char(t, n)));
        n++;
        hold = 1'b0;
      end else begin
        hold = tx_valid;
        hd = tx_data;
      end
      @(negedge clk);
    end
    rx_valid = 1'b0;
    tx_ready = 1'b0;
    check(n == LEN, "R6 report length", n, LEN);
    check(tx_valid === 1'b0, "R8 valid drops after LF", int'(tx_valid), 0);
    if (inj == 8'h67) model_run = 1'b1;
    if (inj == 8'h73 || inj == 8'h63) model_run = 1'b0;
    check(sw_run === model_run, "R9 command during report", int'(sw_run), int'(model_run));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(sw_run === 1'b0 && sw_clear === 1'b0 && tx_valid === 1'b0, "R10 reset state",
          int'({sw_run, sw_clear, tx_valid}), 0);
    rst_n = 1'b1;

    send_cmd(8'h67); model_run = 1'b1;
    check(sw_run === 1'b1, "R1 start", int'(sw_run), 1);
    send_cmd(8'h41);
    check(sw_run === 1'b1 && sw_clear === 1'b0 && tx_valid === 1'b0, "R4 ignored byte",
          int'({sw_run, sw_clear, tx_valid}), 4);
    send_cmd(8'h47);
    check(sw_run === 1'b1 && sw_clear === 1'b0 && tx_valid === 1'b0, "R4 upper case ignored",
          int'({sw_run, sw_clear, tx_valid}), 4);
    send_cmd(8'h63); model_run = 1'b0;
    check(sw_clear === 1'b1 && sw_run === 1'b0, "R3 clear while running",
          int'({sw_run, sw_clear}), 1);
    @(negedge clk);
    check(sw_clear === 1'b0, "R3 clear single cycle", int'(sw_clear), 0);
    send_cmd(8'h67); model_run = 1'b1;
    send_cmd(8'h73); model_run = 1'b0;
    check(sw_run === 1'b0, "R2 stop", int'(sw_run), 0);

    do_report(16'h1234, 8'h00);
    do_report(16'h0000, 8'h00);
    do_report(16'h9999, 8'h67);
    do_report(16'h5078, 8'h73);
    do_report(16'h0409, 8'h74);
    do_report(16'h8016, 8'h63);

    for (int i = 0; i < 300; i++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 5);
      case (r)
        0: b = 8'h67;
        1: b = 8'h73;
        2: b = 8'h63;
        default: begin
          b = 8'($urandom);
          if (b == 8'h67 || b == 8'h73 || b == 8'h63 || b == 8'h74) b = 8'h00;
        end
      endcase
      if (r == 5 && (i % 10) == 0) begin
        logic [4*NDIG-1:0] t;
        logic [7:0] inj;
        for (int d = 0; d < NDIG; d++) t[4*d +: 4] = 4'($urandom_range(0, 9));
        case ($urandom_range(0, 3))
          0: inj = 8'h00;
          1: inj = 8'h67;
          2: inj = 8'h73;
          default: inj = 8'h74;
        endcase
        do_report(t, inj);
      end else begin
        send_cmd(b);
        if (b == 8'h67) model_run = 1'b1;
        if (b == 8'h73 || b == 8'h63) model_run = 1'b0;
        check(sw_run === model_run, "R1 R2 R3 R4 random run", int'(sw_run), int'(model_run));
        check(sw_clear === (b == 8'h63), "R3 R4 random clear", int'(sw_clear), int'(b == 8'h63));
        check(tx_valid === 1'b0, "R4 no report", int'(tx_valid), 0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule